// File: doc/BRIEF.md
# DMA Bus Ownership and Release Arbiter

This block decides who drives the external bus in a system where a DMA engine has the highest priority. The DMA engine owns the bus by default. Three lower-priority requesters compete for it: a DRAM refresh requester, an external bus-release requester and the internal masters (CPU and other on-chip initiators). The arbiter watches a set of pulses from the DMA engine: read half done, write half done, channel switch, end of burst and end of block. It also watches the transfer mode and a give-up configuration bit. It hands the bus away only at the points those inputs allow. A DMA transfer is one read followed by one write, and it is never split by another owner.

When a release point comes and requests are pending, the arbiter opens a round. The round is a snapshot of the pending requesters. Its members are served one at a time in fixed priority order, and each member holds the bus for as long as it keeps its request high. When the round is empty, the bus goes back to the DMA engine. If the DMA engine is idle (not requesting and not inside a transfer), it parks on the bus but gives it up as soon as anyone else asks.

All grants are registered. An event sampled on one clock edge moves the grant on that same edge, so the change is visible from the next cycle. No port carries a data stream, so every pin is a plain level or a pulse, and there is no handshake at the edge of the block.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, `gnt_dma` is 1 and every bit of `lp_gnt` is 0.
- R2: In every cycle exactly one of `gnt_dma` and the `lp_gnt` bits is 1. A grant moves only on a rising clock edge, in response to the inputs sampled at that edge.
- R3: From the cycle in which `dma_rd_done` is sampled while the DMA engine holds the bus, up to and including the cycle in which `dma_wr_done` arrives, the bus stays with the DMA engine whatever the other requests, the mode or the give-up bit.
- R4: In cycle-steal mode (`dma_mode` = 00), every `dma_wr_done` is a release point.
- R5: In burst mode (`dma_mode` = 01), `dma_wr_done` is a release point only together with `dma_burst_end`. In block mode (`dma_mode` = 10 or 11), it is a release point only together with `dma_block_end`. Both cases assume `dma_give_up` = 0.
- R6: `dma_wr_done` together with `dma_ch_switch` is a release point in every mode.
- R7: With `dma_give_up` = 1 in burst or block mode, every `dma_wr_done` is a release point. `dma_rd_done` is never a release point. While the DMA engine is requesting, it keeps the bus in every cycle without `dma_wr_done`.
- R8: At a release point with pending requests, the first pending requester in the fixed order takes the bus: index 0 (refresh), then index 1 (external release), then index 2 (internal masters).
- R9: A granted requester keeps the bus while its request stays high. When the request drops, the bus passes to the next round member that is still requesting. If no such member remains, the bus returns to the DMA engine.
- R10: A requester already served in a round is not granted again until the DMA engine has had the bus back, even if it raises its request again during the round.
- R11: When the DMA engine holds the bus, is not requesting and is not inside a transfer, any pending lower-priority request opens a round on the next edge.
- R12: At a release point with no pending request, the DMA engine keeps the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | DMA engine wants the bus |
| dma_mode | input | 2 | Transfer mode: 00 cycle steal, 01 burst, 1x block |
| dma_rd_done | input | 1 | Pulse: the read half of a transfer is complete |
| dma_wr_done | input | 1 | Pulse: the write half of a transfer is complete |
| dma_ch_switch | input | 1 | With `dma_wr_done`: the next transfer is on another channel |
| dma_burst_end | input | 1 | With `dma_wr_done`: last transfer of a burst |
| dma_block_end | input | 1 | With `dma_wr_done`: last transfer of a block |
| dma_give_up | input | 1 | Give up the bus after each write in burst or block mode |
| lp_req | input | NREQ (3) | Lower-priority requests, index 0 highest priority |
| gnt_dma | output | 1 | Bus granted to the DMA engine |
| lp_gnt | output | NREQ (3) | Bus granted to a lower-priority requester |

## Verification
The hardest case to reach is a round in which a requester that was already served raises its request again while later members are still being served. It is also hard to combine that with requests that drop before their turn. The directed part builds this case deliberately: all three requesters are pending at a cycle-steal write, and they are then released one by one, with the refresh request raised again partway through. The random part drives a DMA engine that obeys the read-before-write rule. Its requesters hold the bus for random lengths of time and raise and drop their requests at random. A bench model tracks the expected owner every cycle, so the mid-transfer window is crossed by every mix of pending requests.

// File: rtl/dab_pkg.sv
package dab_pkg;
  localparam logic [1:0] MODE_STEAL = 2'b00;
  localparam logic [1:0] MODE_BURST = 2'b01;

  function automatic logic is_block(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/dab_release_detect.sv
module dab_release_detect
  import dab_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       own_dma,
  input  logic       dma_req,
  input  logic [1:0] dma_mode,
  input  logic       dma_rd_done,
  input  logic       dma_wr_done,
  input  logic       dma_ch_switch,
  input  logic       dma_burst_end,
  input  logic       dma_block_end,
  input  logic       dma_give_up,
  output logic       mid,
  output logic       rel_now
);
  logic mid_q;
  logic steal_m, burst_m, block_m;
  logic write_rel, idle_rel;

  // Inside a transfer from the read half to the write half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
    end else if (own_dma) begin
      if (dma_wr_done)      mid_q <= 1'b0;
      else if (dma_rd_done) mid_q <= 1'b1;
    end
  end

  assign steal_m = (dma_mode == MODE_STEAL);
  assign burst_m = (dma_mode == MODE_BURST);
  assign block_m = is_block(dma_mode);

  // A write completion is the only point where an active transfer may yield.
  assign write_rel = own_dma && dma_wr_done &&
                     (steal_m || dma_ch_switch ||
                      (burst_m && dma_burst_end) ||
                      (block_m && dma_block_end) ||
                      (dma_give_up && !steal_m));

  // The engine is parked and idle: let anyone else in.
  assign idle_rel = own_dma && !dma_req && !mid_q && !dma_rd_done;

  assign rel_now = write_rel || idle_rel;
  assign mid     = mid_q;
endmodule

// File: rtl/dab_priority_pick.sv
module dab_priority_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] onehot,
  output logic         any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign onehot[i]  = req[i] && !seen[i];
    assign seen[i+1]  = seen[i] || req[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/dab_owner.sv
module dab_owner #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rel_now,
  input  logic [N-1:0] lp_req,
  output logic         gnt_dma,
  output logic [N-1:0] lp_gnt
);
  logic         dma_q, dma_n;
  logic [N-1:0] gnt_q, gnt_n;
  logic [N-1:0] round_q, round_n;
  logic [N-1:0] fresh_oh, rest_oh, rest_req;
  logic         fresh_any, rest_any;

  assign rest_req = round_q & lp_req;

  dab_priority_pick #(.N(N)) u_fresh (
    .req    (lp_req),
    .onehot (fresh_oh),
    .any    (fresh_any)
  );

  dab_priority_pick #(.N(N)) u_rest (
    .req    (rest_req),
    .onehot (rest_oh),
    .any    (rest_any)
  );

  always_comb begin
    dma_n   = dma_q;
    gnt_n   = gnt_q;
    round_n = round_q;
    if (dma_q) begin
      if (rel_now && fresh_any) begin
        dma_n   = 1'b0;
        gnt_n   = fresh_oh;
        round_n = lp_req & ~fresh_oh;
      end
    end else if ((gnt_q & lp_req) == '0) begin
      if (rest_any) begin
        gnt_n   = rest_oh;
        round_n = round_q & ~rest_oh;
      end else begin
        dma_n   = 1'b1;
        gnt_n   = '0;
        round_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q   <= 1'b1;
      gnt_q   <= '0;
      round_q <= '0;
    end else begin
      dma_q   <= dma_n;
      gnt_q   <= gnt_n;
      round_q <= round_n;
    end
  end

  assign gnt_dma = dma_q;
  assign lp_gnt  = gnt_q;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dma_req,
  input  logic [1:0]      dma_mode,
  input  logic            dma_rd_done,
  input  logic            dma_wr_done,
  input  logic            dma_ch_switch,
  input  logic            dma_burst_end,
  input  logic            dma_block_end,
  input  logic            dma_give_up,
  input  logic [NREQ-1:0] lp_req,
  output logic            gnt_dma,
  output logic [NREQ-1:0] lp_gnt
);
  logic mid_w;
  logic rel_w;

  dab_release_detect u_rel (
    .clk           (clk),
    .rst_n         (rst_n),
    .own_dma       (gnt_dma),
    .dma_req       (dma_req),
    .dma_mode      (dma_mode),
    .dma_rd_done   (dma_rd_done),
    .dma_wr_done   (dma_wr_done),
    .dma_ch_switch (dma_ch_switch),
    .dma_burst_end (dma_burst_end),
    .dma_block_end (dma_block_end),
    .dma_give_up   (dma_give_up),
    .mid           (mid_w),
    .rel_now       (rel_w)
  );

  dab_owner #(.N(NREQ)) u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .rel_now (rel_w),
    .lp_req  (lp_req),
    .gnt_dma (gnt_dma),
    .lp_gnt  (lp_gnt)
  );
endmodule

// File: rtl/dab_checker.sv
module dab_checker #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dma_req,
  input logic [1:0]   dma_mode,
  input logic         dma_rd_done,
  input logic         dma_wr_done,
  input logic [N-1:0] lp_req,
  input logic         gnt_dma,
  input logic [N-1:0] lp_gnt,
  input logic         mid
);
  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_dma, lp_gnt}) == 1);

  // R3
  no_split_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_dma && mid && !dma_wr_done) |=> gnt_dma);

  // R7
  release_only_at_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_dma && dma_req && !dma_wr_done) |=> gnt_dma);

  // R4
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_dma && dma_wr_done && dma_mode == 2'b00 && lp_req != '0) |=> !gnt_dma);

  // R9
  hold_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lp_gnt & lp_req) != '0) |=> (lp_gnt == $past(lp_gnt)));
endmodule

bind dma_bus_arbiter dab_checker #(.N(NREQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dma_req     (dma_req),
  .dma_mode    (dma_mode),
  .dma_rd_done (dma_rd_done),
  .dma_wr_done (dma_wr_done),
  .lp_req      (lp_req),
  .gnt_dma     (gnt_dma),
  .lp_gnt      (lp_gnt),
  .mid         (mid_w)
);

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_req = 1'b0;
  logic [1:0] dma_mode = 2'b00;
  logic dma_rd_done = 1'b0, dma_wr_done = 1'b0;
  logic dma_ch_switch = 1'b0, dma_burst_end = 1'b0, dma_block_end = 1'b0;
  logic dma_give_up = 1'b0;
  logic [N-1:0] lp_req = '0;
  logic gnt_dma;
  logic [N-1:0] lp_gnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_bus_arbiter #(.NREQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_mode(dma_mode),
    .dma_rd_done(dma_rd_done), .dma_wr_done(dma_wr_done),
    .dma_ch_switch(dma_ch_switch), .dma_burst_end(dma_burst_end),
    .dma_block_end(dma_block_end), .dma_give_up(dma_give_up),
    .lp_req(lp_req), .gnt_dma(gnt_dma), .lp_gnt(lp_gnt)
  );

  localparam logic [3:0] G_DMA = 4'b1000;
  localparam logic [3:0] G_REF = 4'b0001;
  localparam logic [3:0] G_EXT = 4'b0010;
  localparam logic [3:0] G_CPU = 4'b0100;

  // Bench model of the owner, built from the requirements
  logic       e_dma;
  logic [2:0] e_gnt, e_round;
  logic       e_mid;

  function automatic logic write_release(input logic [1:0] m, input logic ch,
                                         input logic be, input logic ke, input logic gu);
    return (m == 2'b00) || ch || (m == 2'b01 && be) || (m[1] && ke) || (gu && m != 2'b00);
  endfunction

  function automatic logic [2:0] first_of(input logic [2:0] v);
    if (v[0]) return 3'b001;
    if (v[1]) return 3'b010;
    if (v[2]) return 3'b100;
    return 3'b000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_dma = 1'b1; e_gnt = '0; e_round = '0; e_mid = 1'b0;
    end else begin
      logic rel;
      logic [2:0] pick;
      rel = 1'b0;
      if (e_dma) begin
        if (dma_wr_done)
          rel = write_release(dma_mode, dma_ch_switch, dma_burst_end, dma_block_end, dma_give_up);
        else if (!dma_req && !e_mid && !dma_rd_done)
          rel = 1'b1;
        if (rel && lp_req != '0) begin
          pick = first_of(lp_req);
          e_dma = 1'b0; e_gnt = pick; e_round = lp_req & ~pick;
        end
        if (dma_wr_done) e_mid = 1'b0;
        else if (dma_rd_done) e_mid = 1'b1;
      end else if ((e_gnt & lp_req) == '0) begin
        pick = first_of(e_round & lp_req);
        if (pick != '0) begin
          e_gnt = pick; e_round = e_round & ~pick;
        end else begin
          e_dma = 1'b1; e_gnt = '0; e_round = '0;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grants actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] grants();
    return {gnt_dma, lp_gnt};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_pulses();
    dma_rd_done = 1'b0; dma_wr_done = 1'b0; dma_ch_switch = 1'b0;
    dma_burst_end = 1'b0; dma_block_end = 1'b0;
  endtask

  task automatic do_read();
    dma_rd_done = 1'b1; tick(); clear_pulses();
  endtask

  task automatic do_write(input logic ch, input logic be, input logic ke);
    dma_wr_done = 1'b1; dma_ch_switch = ch; dma_burst_end = be; dma_block_end = ke;
    tick(); clear_pulses();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit mid_b;
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    check("R1 reset", grants(), G_DMA);
    rst_n = 1'b1;
    tick();
    check("R1 after reset", grants(), G_DMA);
    dma_req = 1'b1;

    // Block mode, no give-up
    dma_mode = 2'b10; lp_req = 3'b001;
    do_read();
    check("R3 read half keeps DMA", grants(), G_DMA);
    do_write(0, 0, 0);
    check("R5 block write without end", grants(), G_DMA);
    do_read();
    do_write(0, 0, 1);
    check("R5 block end releases", grants(), G_REF);
    lp_req = 3'b000; tick();
    check("R9 return to DMA", grants(), G_DMA);

    // Cycle steal
    dma_mode = 2'b00; lp_req = 3'b010;
    do_read();
    check("R3 steal read keeps DMA", grants(), G_DMA);
    do_write(0, 0, 0);
    check("R4 steal write releases", grants(), G_EXT);
    lp_req = 3'b000; tick();

    // Burst mode
    dma_mode = 2'b01; lp_req = 3'b100;
    do_read(); do_write(0, 0, 0);
    check("R5 burst write without end", grants(), G_DMA);
    do_read(); do_write(0, 1, 0);
    check("R5 burst end releases", grants(), G_CPU);
    lp_req = 3'b000; tick();

    // Channel switch
    lp_req = 3'b001;
    do_read(); do_write(1, 0, 0);
    check("R6 channel switch releases", grants(), G_REF);
    lp_req = 3'b000; tick();

    // Give-up bit in burst and block mode
    dma_give_up = 1'b1; lp_req = 3'b001;
    do_read();
    check("R7 no release at read", grants(), G_DMA);
    tick(); tick();
    check("R3 held between halves", grants(), G_DMA);
    do_write(0, 0, 0);
    check("R7 give-up burst write releases", grants(), G_REF);
    lp_req = 3'b000; tick();
    dma_mode = 2'b10; lp_req = 3'b010;
    do_read(); do_write(0, 0, 0);
    check("R7 give-up block write releases", grants(), G_EXT);
    lp_req = 3'b000; tick();
    dma_give_up = 1'b0;

    // Ordering and one grant per round
    dma_mode = 2'b00; lp_req = 3'b111;
    do_read(); do_write(0, 0, 0);
    check("R8 refresh first", grants(), G_REF);
    tick(); tick();
    check("R9 holds while requesting", grants(), G_REF);
    lp_req = 3'b110; tick();
    check("R8 external next", grants(), G_EXT);
    lp_req = 3'b101; tick();
    check("R10 refresh not regranted", grants(), G_CPU);
    lp_req = 3'b001; tick();
    check("R10 back to DMA after round", grants(), G_DMA);
    tick();
    check("R7 busy DMA keeps bus", grants(), G_DMA);
    lp_req = 3'b000;

    // Idle release
    dma_req = 1'b0; lp_req = 3'b100; tick();
    check("R11 idle DMA yields", grants(), G_CPU);
    lp_req = 3'b000; tick();
    check("R9 parks on DMA", grants(), G_DMA);

    // Release point with nothing pending
    dma_req = 1'b1;
    do_read(); do_write(0, 0, 0);
    check("R12 nothing pending", grants(), G_DMA);

    // Random phase against the bench model
    mid_b = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      check("R2 model", grants(), {e_dma, e_gnt});
      checks++;
      if ($countones(grants()) != 1) begin
        errors++;
        $display("FAIL R2 one grant: actual %b expected one bit", grants());
      end
      clear_pulses();
      if ($urandom_range(0, 63) == 0) dma_mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 63) == 0) dma_give_up = ~dma_give_up;
      if (!mid_b) dma_req = ($urandom_range(0, 9) != 0);
      if (gnt_dma && dma_req) begin
        if (!mid_b && $urandom_range(0, 2) == 0) begin
          dma_rd_done = 1'b1; mid_b = 1'b1;
        end else if (mid_b && $urandom_range(0, 1) == 0) begin
          dma_wr_done   = 1'b1; mid_b = 1'b0;
          dma_ch_switch = ($urandom_range(0, 7) == 0);
          dma_burst_end = ($urandom_range(0, 3) == 0);
          dma_block_end = ($urandom_range(0, 3) == 0);
        end
      end
      for (int i = 0; i < N; i++) begin
        if (lp_gnt[i]) begin
          if ($urandom_range(0, 3) == 0) lp_req[i] = 1'b0;
        end else if (!lp_req[i]) begin
          if ($urandom_range(0, 7) == 0) lp_req[i] = 1'b1;
        end else if ($urandom_range(0, 31) == 0) begin
          lp_req[i] = 1'b0;
        end
      end
      tick();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule